// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an 8-bit up-counter with a reload value, a clock prescaler and three operating modes. In interval mode it counts strobes from a divided system clock. In event mode it counts edges seen on an external input pin. In pulse-width mode it measures one pulse on that pin and then stops by itself. When the counter rolls past its full value it reloads the stored preload value and keeps going. Every rollover produces a one-cycle wake pulse. When the interrupt enable input is high, the same rollover also produces an interrupt request pulse.

Software writes the whole control word (mode, edge polarity, run bit, prescaler select) with one strobe. It writes the preload value with a second strobe. A preload write made while the counter is stopped also loads the counter, so software can set the start value before it starts a run. The count and the run bit can be read at any time. In pulse-width mode the run bit clears itself when the pulse ends, and the count left behind is the measured width. A power-down flag freezes the two modes that use the internal clock. Event counting keeps running while the flag is set.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset, the count is 0, the run bit is 0, and both irq_o and wake_o are low.
- R2: A preload write made while the run bit is 0 or the mode is 00 loads the counter in the same cycle as the preload register.
- R3: Mode 00 holds the count and raises no wake or interrupt, even with the run bit set and the pin toggling.
- R4: Mode 10 (interval) advances once every 2^(psc+1) cycles, with psc the 3-bit select. The divider restarts on each control write. Starting from preload P, the first rollover lands 2^(psc+1)*(256-P) cycles after the write edge.
- R5: A rollover reloads the counter from the preload register and pulses wake_o for one cycle. The wake pulse and the reloaded count appear on the same edge.
- R6: irq_o pulses together with wake_o only while irq_en_i is high. Otherwise irq_o stays low.
- R7: Mode 01 (event) with edge-select 0 counts rising pin edges and ignores falling ones.
- R8: Mode 01 with edge-select 1 counts falling pin edges and ignores rising ones.
- R9: While pdown_i is high, event counting continues and interval counting holds its value. Interval counting resumes when pdown_i drops.
- R10: Mode 11 (pulse width) with edge-select 0 starts on a falling edge and stops on the next rising edge. With edge-select 1 it starts on a rising edge and stops on the next falling edge. It counts prescaled ticks, restarting the divider at the start edge, so a pulse of L cycles adds floor((L-1)/2^(psc+1)). The run bit then clears itself.
- R11: Once a measurement has ended, further pin transitions leave the count unchanged until a control write sets the run bit again. A new measurement then works.
- R12: With the run bit 0, the count holds in every mode.
- R13: A pin edge changes the count on the third rising clock edge after the pin changes: two synchronizer stages, then the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External timer pin, asynchronous |
| pdown_i | input | 1 | Host power-down flag |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_mode_i | input | 2 | Mode: 00 off, 01 event, 10 interval, 11 pulse width |
| ctl_edge_i | input | 1 | Edge-select bit |
| ctl_on_i | input | 1 | Run bit value to write |
| ctl_psc_i | input | PSW | Prescaler select |
| irq_en_i | input | 1 | Timer interrupt enable |
| pre_we_i | input | 1 | Preload write strobe |
| pre_data_i | input | CW | Preload value |
| cnt_o | output | CW | Current count |
| run_o | output | 1 | Current run bit |
| irq_o | output | 1 | Rollover interrupt request pulse |
| wake_o | output | 1 | Rollover wake pulse |

## Verification
Pin-driven results are due on the third rising edge after the pin change, so the bench reads them at the falling edge that follows. Interval rollovers are due exactly 2^(psc+1)*(256-P) edges after the control write edge. The bench counts edges from the write and queues that expected cycle together with the reload value and the interrupt level. A monitor then compares each wake pulse against the head of the queue. For pulse widths, the bench waits until the measurement is over and compares the count with floor((L-1)/2^(psc+1)). It also checks that the count does not move during hold periods and that events are ignored where the requirements say they are.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } tmr_mode_e;

  // low-bit mask whose all-ones value marks one prescaler period
  function automatic logic [255:0] div_mask(input int unsigned sel);
    logic [255:0] m;
    m = '0;
    for (int i = 0; i < 256; i++) if (i <= int'(sel)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= {s_q[1:0], pin_i};
  end

  assign rise_o =  s_q[1] & ~s_q[2];
  assign fall_o = ~s_q[1] &  s_q[2];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [PSW-1:0] sel_i,
  output logic           tick_o
);
  import tmr_evt_pkg::*;
  localparam int DIVW = 1 << PSW;

  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] mask;

  assign mask   = DIVW'(div_mask(int'(sel_i)));
  assign tick_o = en_i && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CW  = 8,
  parameter int PSW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  tick_i,
  input  logic                  pdown_i,
  input  logic                  ctl_we_i,
  input  tmr_evt_pkg::tmr_mode_e ctl_mode_i,
  input  logic                  ctl_edge_i,
  input  logic                  ctl_on_i,
  input  logic [PSW-1:0]        ctl_psc_i,
  input  logic                  irq_en_i,
  input  logic                  pre_we_i,
  input  logic [CW-1:0]         pre_data_i,
  output logic [CW-1:0]         cnt_o,
  output logic [CW-1:0]         pre_o,
  output tmr_evt_pkg::tmr_mode_e mode_o,
  output logic [PSW-1:0]        psc_o,
  output logic                  run_o,
  output logic                  step_o,
  output logic                  ovf_o,
  output logic                  pw_start_o,
  output logic                  wake_o,
  output logic                  irq_o
);
  import tmr_evt_pkg::*;

  tmr_mode_e     mode_q;
  logic          edge_q, on_q, meas_q, wake_q, irq_q;
  logic [PSW-1:0] psc_q;
  logic [CW-1:0] cnt_q, pre_q;
  logic          go_edge, end_edge, evt_edge, pw_stop, active;

  assign go_edge  = edge_q ? rise_i : fall_i;
  assign end_edge = edge_q ? fall_i : rise_i;
  assign evt_edge = edge_q ? fall_i : rise_i;
  assign active   = on_q && (mode_q != MODE_OFF);

  assign pw_start_o = on_q && (mode_q == MODE_PW) && !meas_q && go_edge;
  assign pw_stop    = on_q && (mode_q == MODE_PW) &&  meas_q && end_edge;

  always_comb begin
    unique case (mode_q)
      MODE_TMR: step_o = on_q && tick_i && !pdown_i;
      MODE_EVT: step_o = on_q && evt_edge;
      MODE_PW:  step_o = on_q && meas_q && tick_i && !pdown_i && !end_edge;
      default:  step_o = 1'b0;
    endcase
  end

  assign ovf_o = step_o && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      edge_q <= 1'b0;
      on_q   <= 1'b0;
      psc_q  <= '0;
      meas_q <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      wake_q <= ovf_o;
      irq_q  <= ovf_o && irq_en_i;
      if (pre_we_i) pre_q <= pre_data_i;
      if (ovf_o)                      cnt_q <= pre_q;
      else if (step_o)                cnt_q <= cnt_q + 1'b1;
      else if (pre_we_i && !active)   cnt_q <= pre_data_i;
      if (ctl_we_i) begin
        mode_q <= ctl_mode_i;
        edge_q <= ctl_edge_i;
        on_q   <= ctl_on_i;
        psc_q  <= ctl_psc_i;
        meas_q <= 1'b0;
      end else if (pw_start_o) begin
        meas_q <= 1'b1;
      end else if (pw_stop) begin
        meas_q <= 1'b0;
        on_q   <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pre_o  = pre_q;
  assign mode_o = mode_q;
  assign psc_o  = psc_q;
  assign run_o  = on_q;
  assign wake_o = wake_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit #(
  parameter int CW  = 8,
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_i,
  input  logic           pdown_i,
  input  logic           ctl_we_i,
  input  logic [1:0]     ctl_mode_i,
  input  logic           ctl_edge_i,
  input  logic           ctl_on_i,
  input  logic [PSW-1:0] ctl_psc_i,
  input  logic           irq_en_i,
  input  logic           pre_we_i,
  input  logic [CW-1:0]  pre_data_i,
  output logic [CW-1:0]  cnt_o,
  output logic           run_o,
  output logic           irq_o,
  output logic           wake_o
);
  import tmr_evt_pkg::*;

  logic           rise_w, fall_w, tick_w, step_w, ovf_w, pw_start_w;
  logic [CW-1:0]  pre_w;
  logic [PSW-1:0] psc_w;
  tmr_mode_e      mode_w;

  tmr_pin_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  tmr_prescaler #(.PSW(PSW)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ctl_we_i | pw_start_w),
    .en_i   (!pdown_i),
    .sel_i  (psc_w),
    .tick_o (tick_w)
  );

  tmr_core #(.CW(CW), .PSW(PSW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .tick_i     (tick_w),
    .pdown_i    (pdown_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_mode_i (tmr_mode_e'(ctl_mode_i)),
    .ctl_edge_i (ctl_edge_i),
    .ctl_on_i   (ctl_on_i),
    .ctl_psc_i  (ctl_psc_i),
    .irq_en_i   (irq_en_i),
    .pre_we_i   (pre_we_i),
    .pre_data_i (pre_data_i),
    .cnt_o      (cnt_o),
    .pre_o      (pre_w),
    .mode_o     (mode_w),
    .psc_o      (psc_w),
    .run_o      (run_o),
    .step_o     (step_w),
    .ovf_o      (ovf_w),
    .pw_start_o (pw_start_w),
    .wake_o     (wake_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk #(
  parameter int CW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_we_i,
  input logic                   pre_we_i,
  input logic                   irq_en_i,
  input tmr_evt_pkg::tmr_mode_e mode_w,
  input logic                   run_o,
  input logic [CW-1:0]          cnt_o,
  input logic [CW-1:0]          pre_w,
  input logic                   step_w,
  input logic                   wake_o,
  input logic                   irq_o
);
  import tmr_evt_pkg::*;

  // R5
  reload_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> cnt_o == $past(pre_w));

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (wake_o && $past(irq_en_i)));

  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_w && !pre_we_i) |=> $stable(cnt_o));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> (wake_o || cnt_o == CW'($past(cnt_o) + 1'b1)));

  // R3
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_OFF) |-> !step_w);

  // R10
  self_clear_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_o) && !$past(ctl_we_i)) |-> $past(mode_w) == MODE_PW);
endmodule

bind tmr_evt_unit tmr_evt_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_we_i (ctl_we_i),
  .pre_we_i (pre_we_i),
  .irq_en_i (irq_en_i),
  .mode_w   (mode_w),
  .run_o    (run_o),
  .cnt_o    (cnt_o),
  .pre_w    (pre_w),
  .step_w   (step_w),
  .wake_o   (wake_o),
  .irq_o    (irq_o)
);

// File: tb/test_tmr_evt_unit.sv
`timescale 1ns/1ps
module test_tmr_evt_unit;
  localparam int CW = 8, PSW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, pin = 1'b0, pdown = 1'b0;
  logic ctl_we = 1'b0, ctl_edge = 1'b0, ctl_on = 1'b0, irq_en = 1'b0;
  logic [1:0] ctl_mode = 2'b00;
  logic [PSW-1:0] ctl_psc = '0;
  logic pre_we = 1'b0;
  logic [CW-1:0] pre_data = '0;
  logic [CW-1:0] cnt;
  logic run, irq, wake;

  tmr_evt_unit #(.CW(CW), .PSW(PSW)) i_tmr_evt_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pdown_i(pdown),
    .ctl_we_i(ctl_we), .ctl_mode_i(ctl_mode), .ctl_edge_i(ctl_edge),
    .ctl_on_i(ctl_on), .ctl_psc_i(ctl_psc), .irq_en_i(irq_en),
    .pre_we_i(pre_we), .pre_data_i(pre_data),
    .cnt_o(cnt), .run_o(run), .irq_o(irq), .wake_o(wake)
  );

  typedef struct { string req; int cyc; logic [CW-1:0] val; logic irq; } exp_t;
  exp_t sb[$];
  int cyc = 0, n_run = 0, n_fail = 0, c_last = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor: every wake pulse is matched against the queue head
  always @(negedge clk) begin
    if (rst_n && wake) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R5: actual unexpected wake at %0d expected none", cyc);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " cycle"}, cyc, e.cyc);
        chk({e.req, " reload"}, int'(cnt), int'(e.val));
        chk({e.req, " irq"}, int'(irq), int'(e.irq));
      end
    end else if (rst_n && irq) begin
      n_run++; n_fail++;
      $display("FAIL R6: actual irq without wake expected 0");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic [1:0] m, input logic e, input logic on, input logic [PSW-1:0] p);
    @(negedge clk);
    ctl_mode = m; ctl_edge = e; ctl_on = on; ctl_psc = p; ctl_we = 1'b1;
    c_last = cyc;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic pre(input logic [CW-1:0] v);
    @(negedge clk);
    pre_data = v; pre_we = 1'b1;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin = v;
    c_last = cyc;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
    chk("R5 queue drained", sb.size(), 0);
  endtask

  initial begin
    int v;
    idle(3);
    // R1 reset state
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 run", int'(run), 0);
    chk("R1 wake/irq", int'(wake | irq), 0);
    rst_n = 1'b1;
    idle(3);

    // R2 preload while stopped loads counter
    pre(8'hF0);
    chk("R2 stopped load", int'(cnt), 8'hF0);

    // R4 interval rollover timing, R5 reload, R6 irq on
    irq_en = 1'b1;
    ctl(2'b10, 1'b0, 1'b1, 3'd0);
    sb.push_back('{"R4 psc0", c_last + 1 + 2 * 16, 8'hF0, 1'b1});
    drain();
    ctl(2'b00, 1'b0, 1'b0, 3'd0);

    // R4 ratio 4, R6 irq disabled
    pre(8'hF0);
    irq_en = 1'b0;
    ctl(2'b10, 1'b0, 1'b1, 3'd1);
    sb.push_back('{"R6 psc1 no irq", c_last + 1 + 4 * 16, 8'hF0, 1'b0});
    drain();
    ctl(2'b00, 1'b0, 1'b0, 3'd0);

    // R3 mode 00 with run set holds
    pre(8'h33);
    ctl(2'b00, 1'b0, 1'b1, 3'd0);
    for (int i = 0; i < 4; i++) begin set_pin(~pin); idle(6); end
    chk("R3 off holds", int'(cnt), 8'h33);

    // R12 run bit 0 in interval mode holds
    ctl(2'b10, 1'b0, 1'b0, 3'd0);
    idle(40);
    chk("R12 stopped holds", int'(cnt), 8'h33);

    // R9 interval frozen by power-down
    pre(8'h10);
    ctl(2'b10, 1'b0, 1'b1, 3'd0);
    idle(6);
    pdown = 1'b1;
    idle(2);
    v = int'(cnt);
    idle(30);
    chk("R9 interval frozen", int'(cnt), v);
    pdown = 1'b0;
    idle(10);
    chk("R9 interval resumes", int'(cnt > 8'(v)), 1);
    ctl(2'b00, 1'b0, 1'b0, 3'd0);

    // R7 event rising, under power-down (R9)
    pdown = 1'b1;
    set_pin(1'b0); idle(6);
    pre(8'hFE);
    irq_en = 1'b1;
    ctl(2'b01, 1'b0, 1'b1, 3'd0);
    idle(4);
    set_pin(1'b1); idle(6);
    chk("R7 rise counted (R9 in pdown)", int'(cnt), 8'hFF);
    set_pin(1'b0); idle(6);
    chk("R7 fall ignored", int'(cnt), 8'hFF);
    set_pin(1'b1);
    sb.push_back('{"R5 event rollover", c_last + 3, 8'hFE, 1'b1});
    idle(6);
    drain();

    // R8 event falling and R13 latency
    ctl(2'b00, 1'b0, 1'b0, 3'd0);
    pre(8'h40);
    ctl(2'b01, 1'b1, 1'b1, 3'd0);
    idle(4);
    set_pin(1'b0);
    idle(2);
    chk("R13 not yet at 2 edges", int'(cnt), 8'h40);
    idle(1);
    chk("R13 counted at 3rd edge", int'(cnt), 8'h41);
    set_pin(1'b1); idle(6);
    chk("R8 rise ignored", int'(cnt), 8'h41);
    set_pin(1'b0); idle(6);
    chk("R8 fall counted", int'(cnt), 8'h42);
    pdown = 1'b0;

    // R10 pulse width, edge 0, low pulse of 21 cycles
    ctl(2'b00, 1'b0, 1'b0, 3'd0);
    set_pin(1'b1); idle(6);
    pre(8'h00);
    ctl(2'b11, 1'b0, 1'b1, 3'd0);
    idle(5);
    chk("R10 armed run", int'(run), 1);
    set_pin(1'b0); idle(20); set_pin(1'b1);
    idle(10);
    chk("R10 width low pulse", int'(cnt), (21 - 1) / 2);
    chk("R10 run self-cleared", int'(run), 0);

    // R11 later transitions ignored
    set_pin(1'b0); idle(10); set_pin(1'b1); idle(10);
    chk("R11 ignored after end", int'(cnt), 10);

    // R11 re-arm, R10 edge 1, high pulse of 9 cycles
    set_pin(1'b0); idle(6);
    pre(8'h10);
    ctl(2'b11, 1'b1, 1'b1, 3'd0);
    idle(5);
    set_pin(1'b1); idle(8); set_pin(1'b0);
    idle(10);
    chk("R11 re-armed width high pulse", int'(cnt), 8'h10 + (9 - 1) / 2);
    chk("R10 run cleared again", int'(run), 0);

    idle(5);
    finish_run();
  end
endmodule